// File: doc/BRIEF.md
# Shifted-Pattern Triplet Coincidence Finder

This block searches for circular track candidates that start at a known collision point and cross three cylindrical detector layers. For one event, hits from the two inner layers are written into two azimuth occupancy arrays of 128 bins. Each inner-layer hit is first rescaled by a per-layer factor onto the common azimuth grid. The block then takes the outer-layer hits one per clock. For each one it rotates both arrays so that the outer hit lands at bin 64. A single shared bank of AND gates compares the rotated arrays against a fixed coincidence map, and the resulting bit map goes to a downstream decoder.

The map does not change under rotation, so one coincidence bank serves every outer azimuth. There are no nested loops over all hit combinations. An event runs in four steps. `clear` empties the arrays. Inner hits are streamed in at one per clock. `start` enters the search phase, which is flagged by `busy`. Outer hits are then streamed in and each yields one map. Both the hit input and the map output are valid/ready streams. An outer hit is accepted only while `busy` is high and the output register is empty or being drained in the same cycle. Inner hits and untagged items are always accepted at once. `out_map` and `out_valid` hold steady while `out_ready` is low.

Top module: `tcf_triplet_finder`

## Requirements
- R1: After reset, `busy` and `out_valid` are low, `in_ready` is low for an outer-layer item, and both arrays are empty, so a search gives an all-zero map.
- R2: Layer tag 1 marks the first layer and tag 2 the second. An accepted hit outside the search phase sets bin floor(phi*Lk_NUM / 2^SCALE_SH) mod 128 in its layer's array. The defaults are L1_NUM=64, L2_NUM=128 and SCALE_SH=6, so layer 1 keeps phi and layer 2 stores 2*phi mod 128.
- R3: For an accepted outer hit (tag 3) at phi3, map bit k is set when the layer-1 array holds bin (phi3 + k - 8) mod 128 and the layer-2 array holds bin (phi3 + floor(k/2) - 4) mod 128. These are the offsets 64 - MAP_W/2 + k and 64 - MAP_W/4 + k/2, taken relative to phi3 - 64, with MAP_W=16.
- R4: Each accepted outer hit produces exactly one map. `out_valid` rises on the clock edge that accepts the hit.
- R5: While `out_valid` is high and `out_ready` is low, `out_map` and `out_valid` hold, and `in_ready` is low for outer-layer items.
- R6: Outer-layer items are not accepted while `busy` is low.
- R7: Layer-1 and layer-2 hits accepted during the search phase leave both arrays unchanged.
- R8: `clear` empties both arrays and drops `busy` on the next edge. It wins over a `start` in the same cycle.
- R9: `start` without `clear` raises `busy` on the next edge.
- R10: Rotation wraps modulo 128, so pairs that straddle bin 0 are found for any phi3.
- R11: Items with tag 0 are accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Empty both arrays, leave search phase |
| start | input | 1 | Enter search phase |
| busy | output | 1 | Search phase active |
| in_valid | input | 1 | Hit stream valid |
| in_ready | output | 1 | Hit stream ready |
| in_layer | input | 2 | Layer tag: 0 none, 1, 2, 3 |
| in_phi | input | PHI_W | Azimuth bin of the hit |
| out_valid | output | 1 | Map stream valid |
| out_ready | input | 1 | Map stream ready |
| out_map | output | MAP_W | Coincidence map for one outer hit |

## Verification
A wrong array bit shows up only when an outer hit is searched near it. It then appears one edge after acceptance as a set or missing bit of `out_map` at a position fixed by R3. The stimulus therefore places pairs at bins and offsets where a stray or lost bit, a bad scale, or a wrong rotation direction flips a known map bit. Wrap-around pairs map to bits 0 and 15, where an off-by-one rotation empties the map. A wrong phase or output-register state appears immediately as `in_ready` or `out_valid` at the next sample.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

  typedef enum logic [1:0] {
    TAG_NONE  = 2'd0,
    TAG_INNER = 2'd1,
    TAG_MID   = 2'd2,
    TAG_OUTER = 2'd3
  } layer_tag_e;

  // Position in the rotated layer-1 array that feeds map bit k.
  function automatic int map_inner_pos(input int k, input int nbins, input int mapw);
    return nbins / 2 - mapw / 2 + k;
  endfunction

  // Position in the rotated layer-2 array that feeds map bit k.
  function automatic int map_mid_pos(input int k, input int nbins, input int mapw);
    return nbins / 2 - mapw / 4 + k / 2;
  endfunction

endpackage

// File: rtl/tcf_hit_array.sv
module tcf_hit_array #(
  parameter int PHI_W     = 7,
  parameter int SCALE_NUM = 64,
  parameter int SCALE_SH  = 6,
  localparam int NBINS    = 1 << PHI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [PHI_W-1:0] wr_phi,
  output logic [NBINS-1:0] bits
);

  function automatic logic [PHI_W-1:0] rescale(input logic [PHI_W-1:0] p);
    int unsigned t;
    t = (int'(p) * SCALE_NUM) >> SCALE_SH;
    return PHI_W'(t);
  endfunction

  logic [PHI_W-1:0] bin;
  assign bin = rescale(wr_phi);

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              bits[b] <= 1'b0;
      else if (clr)                            bits[b] <= 1'b0;
      else if (wr_en && bin == PHI_W'(b))      bits[b] <= 1'b1;
    end
  end

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bits == '0));

  assert_store_scaled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> bits[$past(bin)]);

endmodule

// File: rtl/tcf_rotator.sv
module tcf_rotator #(
  parameter int PHI_W  = 7,
  localparam int NBINS = 1 << PHI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBINS-1:0] din,
  input  logic [PHI_W-1:0] amt,
  output logic [NBINS-1:0] dout
);

  // dout[j] = din[(j + amt) mod NBINS], built from log2 stages
  logic [NBINS-1:0] stg [PHI_W+1];
  assign stg[0] = din;

  for (genvar s = 0; s < PHI_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stg[s+1] = amt[s] ? {stg[s][STEP-1:0], stg[s][NBINS-1:STEP]} : stg[s];
  end

  assign dout = stg[PHI_W];

  assert_rot_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dout) == $countones(din));

endmodule

// File: rtl/tcf_coinc.sv
module tcf_coinc #(
  parameter int PHI_W  = 7,
  parameter int MAP_W  = 16,
  localparam int NBINS = 1 << PHI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBINS-1:0] rot_inner,
  input  logic [NBINS-1:0] rot_mid,
  output logic [MAP_W-1:0] hits
);

  for (genvar k = 0; k < MAP_W; k++) begin : g_cell
    localparam int P1 = tcf_pkg::map_inner_pos(k, NBINS, MAP_W);
    localparam int P2 = tcf_pkg::map_mid_pos(k, NBINS, MAP_W);
    assign hits[k] = rot_inner[P1] & rot_mid[P2];
  end

  assert_hit_needs_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|hits) |-> ((rot_inner != '0) && (rot_mid != '0)));

endmodule

// File: rtl/tcf_triplet_finder.sv
module tcf_triplet_finder #(
  parameter int PHI_W    = 7,
  parameter int MAP_W    = 16,
  parameter int L1_NUM   = 64,
  parameter int L2_NUM   = 128,
  parameter int SCALE_SH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             start,
  output logic             busy,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_layer,
  input  logic [PHI_W-1:0] in_phi,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MAP_W-1:0] out_map
);
  import tcf_pkg::*;

  localparam int NBINS = 1 << PHI_W;
  localparam logic [PHI_W-1:0] HALF = PHI_W'(NBINS / 2);

  logic             is_outer, out_free, take, wr_inner, wr_mid, query;
  logic [PHI_W-1:0] rot_amt;
  logic [NBINS-1:0] arr_inner, arr_mid, rot_inner, rot_mid;
  logic [MAP_W-1:0] hits;

  assign is_outer = (in_layer == TAG_OUTER);
  assign out_free = !out_valid || out_ready;
  assign in_ready = is_outer ? (busy && out_free) : 1'b1;
  assign take     = in_valid && in_ready;
  assign wr_inner = take && !busy && (in_layer == TAG_INNER);
  assign wr_mid   = take && !busy && (in_layer == TAG_MID);
  assign query    = take && is_outer;
  assign rot_amt  = in_phi - HALF;

  tcf_hit_array #(.PHI_W(PHI_W), .SCALE_NUM(L1_NUM), .SCALE_SH(SCALE_SH)) u_arr_inner (
    .clk(clk), .rst_n(rst_n), .clr(clear), .wr_en(wr_inner), .wr_phi(in_phi), .bits(arr_inner));

  tcf_hit_array #(.PHI_W(PHI_W), .SCALE_NUM(L2_NUM), .SCALE_SH(SCALE_SH)) u_arr_mid (
    .clk(clk), .rst_n(rst_n), .clr(clear), .wr_en(wr_mid), .wr_phi(in_phi), .bits(arr_mid));

  tcf_rotator #(.PHI_W(PHI_W)) u_rot_inner (
    .clk(clk), .rst_n(rst_n), .din(arr_inner), .amt(rot_amt), .dout(rot_inner));

  tcf_rotator #(.PHI_W(PHI_W)) u_rot_mid (
    .clk(clk), .rst_n(rst_n), .din(arr_mid), .amt(rot_amt), .dout(rot_mid));

  tcf_coinc #(.PHI_W(PHI_W), .MAP_W(MAP_W)) u_coinc (
    .clk(clk), .rst_n(rst_n), .rot_inner(rot_inner), .rot_mid(rot_mid), .hits(hits));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy <= 1'b0;
    else if (clear) busy <= 1'b0;
    else if (start) busy <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_map   <= '0;
    end else if (query) begin
      out_valid <= 1'b1;
      out_map   <= hits;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_one_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    query |=> out_valid);

  assert_hold_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_map)));

  assert_outer_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_outer && !busy) |-> !in_ready);

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !busy);

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clear) |=> busy);

endmodule

// File: tb/tcf_triplet_finder_test.sv
module tcf_triplet_finder_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0, start = 1'b0;
  logic       busy;
  logic       in_valid = 1'b0, in_ready;
  logic [1:0] in_layer = 2'd0;
  logic [6:0] in_phi = 7'd0;
  logic       out_valid, out_ready = 1'b1;
  logic [15:0] out_map;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  tcf_triplet_finder uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .start(start), .busy(busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_layer(in_layer), .in_phi(in_phi),
    .out_valid(out_valid), .out_ready(out_ready), .out_map(out_map));

  // load items {tag, phi}; layer-2 raw phi is doubled mod 128 (R2)
  localparam logic [8:0] LOAD_VEC [12] = '{
    {2'd1, 7'd10},  {2'd2, 7'd5},
    {2'd1, 7'd126}, {2'd2, 7'd63},
    {2'd1, 7'd2},   {2'd2, 7'd1},
    {2'd1, 7'd40},  {2'd2, 7'd20},
    {2'd1, 7'd72},  {2'd2, 7'd100},
    {2'd2, 7'd32},  {2'd0, 7'd64}
  };

  // queries {phi3, expected map}
  localparam logic [22:0] QUERY_VEC [11] = '{
    {7'd10,  16'h0100}, {7'd11,  16'h0080}, {7'd12, 16'h0000},
    {7'd6,   16'h0001}, {7'd123, 16'h8000}, {7'd2,  16'h0100},
    {7'd126, 16'h0100}, {7'd72,  16'h0100}, {7'd80, 16'h0000},
    {7'd41,  16'h0080}, {7'd64,  16'h0000}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] lay, input logic [6:0] ph);
    @(negedge clk);
    in_valid = 1'b1; in_layer = lay; in_phi = ph;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic query(input logic [6:0] p, input logic [15:0] exp, input string req);
    send(2'd3, p);
    check(out_valid == 1'b1, "R4 out_valid after query", int'(out_valid), 1);
    check(out_map == exp, req, int'(out_map), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    in_layer = 2'd3;
    @(negedge clk); #1;
    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b0, "R1 R6 outer not ready while idle", int'(in_ready), 0);
    in_layer = 2'd0;

    pulse_start();
    #1;
    check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    query(7'd10, 16'h0000, "R1 empty arrays give zero map");

    // new event: load both inner layers
    pulse_clear();
    #1;
    check(busy == 1'b0, "R8 busy dropped by clear", int'(busy), 0);
    foreach (LOAD_VEC[i]) send(LOAD_VEC[i][8:7], LOAD_VEC[i][6:0]);
    pulse_start();

    // table walk: R2 scaling, R3 map, R10 wrap, R11 tag 0 dropped
    foreach (QUERY_VEC[i])
      query(QUERY_VEC[i][22:16], QUERY_VEC[i][15:0], "R3 R10 R2 R11 table map");

    // R7: inner hit during search ignored
    send(2'd1, 7'd64);
    query(7'd64, 16'h0000, "R7 inner hit during search ignored");

    // R8: clear beats start
    @(negedge clk); clear = 1'b1; start = 1'b1;
    @(negedge clk); clear = 1'b0; start = 1'b0;
    #1;
    check(busy == 1'b0, "R8 clear wins over start", int'(busy), 0);
    pulse_start();
    query(7'd10, 16'h0000, "R8 arrays emptied by clear");

    // reload a small event
    pulse_clear();
    send(2'd1, 7'd20);
    send(2'd2, 7'd10);
    pulse_start();

    // R5 back-pressure
    out_ready = 1'b0;
    send(2'd3, 7'd20);
    check(out_map == 16'h0100, "R5 first map", int'(out_map), 16'h0100);
    @(negedge clk);
    in_valid = 1'b1; in_layer = 2'd3; in_phi = 7'd21;
    #1;
    check(in_ready == 1'b0, "R5 outer blocked while stalled", int'(in_ready), 0);
    @(negedge clk); #1;
    check(out_valid == 1'b1, "R5 valid held", int'(out_valid), 1);
    check(out_map == 16'h0100, "R5 map held", int'(out_map), 16'h0100);
    check(in_ready == 1'b0, "R5 still blocked", int'(in_ready), 0);
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R5 ready when drained", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b1, "R4 second map valid", int'(out_valid), 1);
    check(out_map == 16'h0080, "R5 second map", int'(out_map), 16'h0080);
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R4 single map per hit", int'(out_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule